// File: doc/BRIEF.md
# Pipeline stage slack-time monitor

This block sits beside one processing stage of a streaming video pipeline. Every frame reaches it as a header of monitoring words followed by the pixels, all on one 36-bit word stream. The block reads the frame width and height from the header and loads its own pixel and line counters from them. It uses these counters to find the last pixel of each frame. From that pixel until the next frame-sync pulse it counts idle clock cycles, and this count is the stage's slack time.

Every word, header or pixel, leaves the block one clock after it is accepted. In the header of the following frame, the block reports its measured slack. It does this only when its own value is smaller than the slack that earlier stages already carry, so the header that leaves the pipeline holds the minimum over all stages. If the header has no slack word, the block adds one just before the stop word. If the header carries a larger value, the block overwrites that value where it stands. Adding a word costs one cycle. A single holding register absorbs that cycle, and the input is stalled for it through a valid/ready handshake.

Top module: `slack_monitor`

## Requirements
- R1: Each word is 36 bits, with a 4-bit code in bits 35:32 and a 32-bit value in bits 31:0. Header words are recognised by position: the first word after reset, and the first word after the last pixel of a frame, opens a header. The header runs up to and including the word with code 1110 (stop). Start codes 1111 and 1010 and delay code 0000 are decoded by their code only. A header word that is not altered leaves unchanged on out_data with out_valid high in the cycle after it is accepted.
- R2: A header word with code 0010 loads bits 13:0 as the frame width, and a word with code 0011 loads bits 13:0 as the frame height (both 1 after reset, and both must be at least 1). The frame ends on the width×height-th pixel word after the stop word, and the word after that opens the next header.
- R3: Pixel words pass through unchanged whatever their upper bits hold, including bits that equal a header code.
- R4: The slack counter is cleared when the last pixel of a frame is accepted and counts one per cycle after that. If fsync is sampled high k clock edges after that acceptance, the captured slack is k−1. An fsync pulse while the counter is not running has no effect.
- R5: The slack counter saturates at 2^SLK_W−1 and does not wrap.
- R6: Until a first slack value has been captured, headers pass unchanged and nothing is added to them.
- R7: A header with no code-0100 word, arriving while a slack value is held, leaves with the word {0100, slack zero-extended to 32 bits} inserted directly before its stop word. The stop word follows one cycle later.
- R8: A code-0100 word whose value is greater than the held slack leaves with its value replaced by the held slack. No further word is added to that header.
- R9: A code-0100 word whose value is less than or equal to the held slack passes unchanged, and no word is added.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold. No word is lost or repeated under back-pressure, and in_ready is low for the cycle in which the delayed stop word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse, one cycle wide |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | 36 | Input word (code 35:32, value 31:0) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 36 | Output word |

## Verification
Two of the block's functions can fall in the same cycle. In one case, the output register is stalled by out_ready while the block has to add a slack word, so the held stop word and the stalled output compete for the output register. In the other case, the width and height just loaded from a header must end the very next frame at the right pixel, while the slack timer restarts from that end point. The bench drives the last two frames with a repeating out_ready pattern while it appends a slack word and changes the frame size. Every output word is compared with a scoreboard entry that was computed from the requirements. A stalled, lost or repeated word, or a frame that ends at the wrong pixel, therefore shows up as a mismatch or as a scoreboard that is not empty at the end.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int WORD_W = 36;
  localparam int CODE_W = 4;
  localparam int VAL_W  = WORD_W - CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam code_t C_OPEN0 = 4'b1111;
  localparam code_t C_OPEN1 = 4'b1010;
  localparam code_t C_CLOSE = 4'b1110;
  localparam code_t C_EMPTY = 4'b0000;
  localparam code_t C_WIDTH = 4'b0010;
  localparam code_t C_HEIGHT = 4'b0011;
  localparam code_t C_SLACK = 4'b0100;

  function automatic code_t code_of(input word_t w);
    return w[WORD_W-1:VAL_W];
  endfunction

  function automatic logic [VAL_W-1:0] value_of(input word_t w);
    return w[VAL_W-1:0];
  endfunction

  function automatic word_t make_word(input code_t c, input logic [VAL_W-1:0] v);
    return {c, v};
  endfunction
endpackage

// File: rtl/slk_frame_cnt.sv
module slk_frame_cnt #(
  parameter int DIM_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pix_fire,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic             frame_end
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic [DIM_W-1:0] col_q, row_q;
  logic line_end;

  assign line_end  = pix_fire && (col_q == width - ONE);
  assign frame_end = line_end && (row_q == height - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_fire) begin
      if (line_end) begin
        col_q <= '0;
        row_q <= frame_end ? '0 : row_q + ONE;
      end else begin
        col_q <= col_q + ONE;
      end
    end
  end
endmodule

// File: rtl/slk_timer.sv
module slk_timer #(
  parameter int SLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             fsync,
  output logic             running,
  output logic [SLK_W-1:0] count,
  output logic             have_slack,
  output logic [SLK_W-1:0] slack
);
  function automatic logic [SLK_W-1:0] sat_inc(input logic [SLK_W-1:0] x);
    return (&x) ? x : x + SLK_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      count      <= '0;
      have_slack <= 1'b0;
      slack      <= '0;
    end else if (frame_end) begin
      running <= 1'b1;
      count   <= '0;
    end else if (running) begin
      if (fsync) begin
        slack      <= count;
        have_slack <= 1'b1;
        running    <= 1'b0;
      end else begin
        count <= sat_inc(count);
      end
    end
  end
endmodule

// File: rtl/slk_out_stage.sv
module slk_out_stage #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] first_word,
  input  logic         add_second,
  input  logic [W-1:0] second_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         can_load;
  logic         held_v;
  logic [W-1:0] held_q;

  assign can_load = out_ready || !out_valid;
  assign in_ready = can_load && !held_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      held_v    <= 1'b0;
      held_q    <= '0;
    end else if (can_load) begin
      if (held_v) begin
        out_data  <= held_q;
        out_valid <= 1'b1;
        held_v    <= 1'b0;
      end else if (in_valid) begin
        out_data  <= first_word;
        out_valid <= 1'b1;
        if (add_second) begin
          held_q <= second_word;
          held_v <= 1'b1;
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slack_monitor.sv
module slack_monitor
  import slk_pkg::*;
#(
  parameter int DIM_W = 14,
  parameter int SLK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic             in_fire;
  logic             in_header;
  logic             slack_seen;
  logic [DIM_W-1:0] width_q, height_q;
  code_t            in_code;
  logic             is_close, is_slack;
  logic             add_cond, repl_cond;
  logic             pix_fire, frame_end, header_done;
  logic             tmr_run, slk_vld;
  logic [SLK_W-1:0] tmr_cnt, slk_val;
  logic [VAL_W-1:0] slk_ext;
  word_t            first_word;

  assign in_fire     = in_valid && in_ready;
  assign in_code     = code_of(in_data);
  assign is_close    = in_header && (in_code == C_CLOSE);
  assign is_slack    = in_header && (in_code == C_SLACK);
  assign slk_ext     = VAL_W'(slk_val);
  assign add_cond    = is_close && !slack_seen && slk_vld;
  assign repl_cond   = is_slack && slk_vld && (value_of(in_data) > slk_ext);
  assign first_word  = (add_cond || repl_cond) ? make_word(C_SLACK, slk_ext) : in_data;
  assign pix_fire    = in_fire && !in_header;
  assign header_done = in_fire && is_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_header  <= 1'b1;
      slack_seen <= 1'b0;
      width_q    <= DIM_W'(1);
      height_q   <= DIM_W'(1);
    end else begin
      if (header_done) begin
        in_header  <= 1'b0;
        slack_seen <= 1'b0;
      end else if (frame_end) begin
        in_header <= 1'b1;
      end
      if (in_fire && is_slack) slack_seen <= 1'b1;
      if (in_fire && in_header && in_code == C_WIDTH)  width_q  <= in_data[DIM_W-1:0];
      if (in_fire && in_header && in_code == C_HEIGHT) height_q <= in_data[DIM_W-1:0];
    end
  end

  slk_frame_cnt #(.DIM_W(DIM_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .restart(header_done), .pix_fire(pix_fire),
    .width(width_q), .height(height_q), .frame_end(frame_end)
  );

  slk_timer #(.SLK_W(SLK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .fsync(fsync),
    .running(tmr_run), .count(tmr_cnt), .have_slack(slk_vld), .slack(slk_val)
  );

  slk_out_stage #(.W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .first_word(first_word), .add_second(add_cond), .second_word(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

module slack_monitor_chk #(
  parameter int SLK_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fsync,
  input logic             in_valid,
  input logic             in_ready,
  input logic [35:0]      in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [35:0]      out_data,
  input logic             add_cond,
  input logic             repl_cond,
  input logic             frame_end,
  input logic             tmr_run,
  input logic [SLK_W-1:0] tmr_cnt,
  input logic             slk_vld,
  input logic [SLK_W-1:0] slk_val
);
  // R1
  pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !add_cond && !repl_cond) |=> (out_valid && out_data == $past(in_data)));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R10
  close_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && add_cond) |=> !in_ready);
  // R7
  added_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && add_cond) |=> (out_valid && out_data[35:32] == 4'b0100));
  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && fsync && !frame_end) |=> (slk_vld && slk_val == $past(tmr_cnt)));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && (&tmr_cnt) && !fsync && !frame_end) |=> (&tmr_cnt));
endmodule

bind slack_monitor slack_monitor_chk #(.SLK_W(SLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .add_cond(add_cond), .repl_cond(repl_cond), .frame_end(frame_end), .tmr_run(tmr_run),
  .tmr_cnt(tmr_cnt), .slk_vld(slk_vld), .slk_val(slk_val)
);

// File: tb/test_slack_monitor.sv
`timescale 1ns/1ps
module test_slack_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;

  int errors = 0;
  int checks = 0;
  bit bp_on = 1'b0;
  logic [35:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  slack_monitor #(.DIM_W(14), .SLK_W(8)) i_slack_monitor (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [35:0] w(input logic [3:0] c, input logic [31:0] v);
    return {c, v};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [35:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic send(input logic [35:0] d);
    bit r;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // hdr: send words, expected words pushed separately
  task automatic pixels(input int n);
    for (int i = 0; i < n; i++) begin
      logic [35:0] p;
      p = (i == 1) ? w(4'b0100, 32'hFFFF_FFF0) : w(4'(i + 5), 32'(i * 17 + 3));
      expect_word(p, "R3");
      send(p);
    end
  endtask

  // slack captured = g-1
  task automatic gap(input int g);
    @(negedge clk);
    repeat (g - 1) @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic hdr_pass(input logic [35:0] d, input string req);
    expect_word(d, req);
    send(d);
  endtask

  // monitor: pops scoreboard on each transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 actual=%h expected=none (extra word)", out_data);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_data, e);
      end
    end
  end

  // back-pressure pattern, changed away from the edges
  initial begin
    logic [7:0] pat;
    pat = 8'b1011_0010;
    forever begin
      @(posedge clk);
      #1;
      pat = {pat[6:0], pat[7]};
      out_ready = bp_on ? pat[0] : 1'b1;
    end
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", {35'd0, out_valid}, 36'd0);
    check("R10 reset in_ready", {35'd0, in_ready}, 36'd1);

    // fsync with timer idle: no effect (R4, R6)
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;

    // Frame 1: nothing measured yet, header unchanged (R6)
    expect_word(w(4'hF, 0), "R6");
    send(w(4'hF, 0));
    @(negedge clk);
    check("R1 latency valid", {35'd0, out_valid}, 36'd1);
    check("R1 latency data", out_data, w(4'hF, 0));
    hdr_pass(w(4'hA, 0), "R6");
    hdr_pass(w(4'h2, 32'h8000_0003), "R2");
    hdr_pass(w(4'h3, 2), "R2");
    hdr_pass(w(4'hE, 0), "R6");
    pixels(6);
    gap(5);   // slack 4

    // Frame 2: no slack word, append (R7)
    hdr_pass(w(4'hF, 0), "R7");
    hdr_pass(w(4'hA, 0), "R7");
    hdr_pass(w(4'h0, 0), "R1 delay word");
    expect_word(w(4'h4, 4), "R7 appended slack");
    hdr_pass(w(4'hE, 0), "R7 stop after append");
    pixels(6);
    gap(10);  // slack 9

    // Frame 3: larger slack replaced in place (R8)
    hdr_pass(w(4'hF, 0), "R8");
    hdr_pass(w(4'hA, 0), "R8");
    expect_word(w(4'h4, 9), "R8 replaced");
    send(w(4'h4, 20));
    hdr_pass(w(4'hE, 0), "R8 no append");
    pixels(6);
    gap(3);   // slack 2

    // Frame 4: lower upstream slack kept (R9)
    hdr_pass(w(4'hF, 0), "R9");
    hdr_pass(w(4'hA, 0), "R9");
    hdr_pass(w(4'h4, 1), "R9 lower kept");
    hdr_pass(w(4'hE, 0), "R9 no append");
    pixels(6);
    gap(3);   // slack 2

    // Frame 5: equal slack kept (R9)
    hdr_pass(w(4'hF, 0), "R9");
    hdr_pass(w(4'hA, 0), "R9");
    hdr_pass(w(4'h4, 2), "R9 equal kept");
    hdr_pass(w(4'hE, 0), "R9 no append");
    pixels(6);
    gap(300); // saturates at 255 (R5)

    // Frame 6: new size 2x1, saturated slack replaces 1000 (R5, R2)
    bp_on = 1'b1;
    hdr_pass(w(4'hF, 0), "R10");
    hdr_pass(w(4'hA, 0), "R10");
    hdr_pass(w(4'h2, 2), "R2");
    hdr_pass(w(4'h3, 1), "R2");
    expect_word(w(4'h4, 255), "R5 saturated slack");
    send(w(4'h4, 1000));
    hdr_pass(w(4'hE, 0), "R10");
    pixels(2);
    gap(7);   // slack 6, only if frame ended after 2 pixels (R2)

    // Frame 7: append under back-pressure (R7, R10, R2)
    hdr_pass(w(4'hF, 0), "R2");
    hdr_pass(w(4'hA, 0), "R10");
    expect_word(w(4'h4, 6), "R2 R7 slack after resize");
    hdr_pass(w(4'hE, 0), "R10 held stop");
    pixels(2);

    bp_on = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 scoreboard drained", 36'(exp_q.size()), 36'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule